// File: doc/BRIEF.md
# Reset and Boot Entry Sequencer

This block decides what a small processor core does after any of its reset sources has fired. While a reset request is present it holds the core idle, keeps the status register cleared, and puts the watchdog and the shared reset/NMI pin into their safe defaults. The watchdog is left enabled in watchdog mode, not interval mode. The pin is left in its reset function.

Once every reset request is gone, the sequencer loads the program counter with a fixed boot entry address and waits for the boot code to report that it is finished. It then reads the start-address word at FFFEh through a simple read port with a valid handshake. A normal word is loaded into the program counter and the core is released to run. A word of FFFFh marks an unprogrammed part. In that case the sequencer makes no jump and parks the core in the deepest low-power mode until the next reset.

Top module: `boot_entry_seq`

## Requirements
- R1: While any of `rst`, `por_req` or `bor_req` is high at a clock edge, the following cycle shows the hold state: `sr_clear`=1, `cpu_run`=0, `lpm4_enter`=0, `mem_rd_req`=0, `pc_load`=0.
- R2: `sr_clear` is high in the hold state and low in every other state.
- R3: After a hold cycle, `wdt_enable`=1 and `wdt_interval_mode`=0 (0 means watchdog mode).
- R4: After a hold cycle, `pin_nmi_sel`=0 (0 means reset function).
- R5: In the first cycle after the hold state is left, `pc_load` is high for exactly one cycle with `pc_value` = `BOOT_ADDR` (default 16'hC000).
- R6: During boot, `mem_rd_req` stays low until `boot_done` is sampled high. From the next cycle `mem_rd_req` is high with `mem_rd_addr` = 16'hFFFE.
- R7: `mem_rd_req` stays high, and `mem_rd_data` has no effect, until `mem_rd_valid` is sampled high.
- R8: When `mem_rd_valid` is sampled with a word other than 16'hFFFF, the next cycle shows `cpu_run`=1 and a one-cycle `pc_load` with `pc_value` equal to that word.
- R9: When `mem_rd_valid` is sampled with the word 16'hFFFF, the next cycle shows `lpm4_enter`=1 with no `pc_load`. The part stays parked until a reset arrives.
- R10: A reset request sampled in the same cycle as `mem_rd_valid` or `boot_done` takes priority: no `pc_load` and no advance happen, and the hold state follows.
- R11: In the run and parked states `boot_done` has no effect, and no further `pc_load` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| por_req | input | 1 | Power-on reset request |
| bor_req | input | 1 | Brown-out reset request |
| boot_done | input | 1 | Boot code reports completion |
| mem_rd_req | output | 1 | Read request for the start-address word |
| mem_rd_addr | output | 16 | Read address (FFFEh) |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data word |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | 16 | Value to load into the program counter |
| sr_clear | output | 1 | Status register held cleared |
| wdt_enable | output | 1 | Watchdog enabled |
| wdt_interval_mode | output | 1 | 1 = interval timer mode, 0 = watchdog mode |
| pin_nmi_sel | output | 1 | 1 = shared pin acts as NMI, 0 = reset function |
| cpu_run | output | 1 | Core released to run the application |
| lpm4_enter | output | 1 | Core parked in deepest low-power mode |

## Verification
Two events can land in the same cycle. A reset request can arrive together with the read-valid that would load the program counter, or together with the boot-done strobe that would start the vector fetch. The bench raises `bor_req` in the very cycle `mem_rd_valid` is presented with a runnable word, and `por_req` together with `boot_done`. It then checks that no load strobe reaches the scoreboard, that the hold state follows, and that the read request is not raised. The scoreboard holds every expected program-counter load, so a stray or missing load is caught as well as a wrong value.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_BOOT   = 3'd1,
        ST_VFETCH = 3'd2,
        ST_RUN    = 3'd3,
        ST_PARK   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic wdt_en;
        logic wdt_interval;
        logic nmi_sel;
    } sys_cfg_t;

    localparam sys_cfg_t CFG_DEFAULT = '{wdt_en: 1'b1, wdt_interval: 1'b0, nmi_sel: 1'b0};

    function automatic logic word_is_blank(input logic [15:0] word, input logic [15:0] pattern);
        return word == pattern;
    endfunction

endpackage

// File: rtl/reset_gather.sv
module reset_gather #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src,
    output logic             any_rst
);
    assign any_rst = |src;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       any_rst,
    input  logic       boot_done,
    input  logic       rd_valid,
    input  logic       blank,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:   nxt = ST_BOOT;
            ST_BOOT:   if (boot_done) nxt = ST_VFETCH;
            ST_VFETCH: if (rd_valid) nxt = blank ? ST_PARK : ST_RUN;
            ST_RUN:    nxt = ST_RUN;
            ST_PARK:   nxt = ST_PARK;
            default:   nxt = ST_HOLD;
        endcase
        if (any_rst) nxt = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        state <= nxt;
    end
endmodule

// File: rtl/pc_loader.sv
module pc_loader
    import boot_seq_pkg::*;
#(
    parameter int          W         = 16,
    parameter logic [W-1:0] BOOT_ADDR = 16'hC000
) (
    input  logic         clk,
    input  logic         any_rst,
    input  seq_state_t   state,
    input  logic         rd_valid,
    input  logic [W-1:0] rd_data,
    input  logic         blank,
    output logic         load,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (any_rst) begin
            load  <= 1'b0;
            value <= '0;
        end else if (state == ST_HOLD) begin
            load  <= 1'b1;
            value <= BOOT_ADDR;
        end else if (state == ST_VFETCH && rd_valid && !blank) begin
            load  <= 1'b1;
            value <= rd_data;
        end else begin
            load  <= 1'b0;
        end
    end
endmodule

// File: rtl/sys_defaults.sv
module sys_defaults
    import boot_seq_pkg::*;
(
    input  logic     clk,
    input  logic     any_rst,
    output sys_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (any_rst) cfg <= CFG_DEFAULT;
    end
endmodule

// File: rtl/boot_entry_seq.sv
module boot_entry_seq
    import boot_seq_pkg::*;
#(
    parameter int           W          = 16,
    parameter logic [W-1:0] BOOT_ADDR  = 16'hC000,
    parameter logic [W-1:0] VEC_ADDR   = 16'hFFFE,
    parameter logic [W-1:0] BLANK_WORD = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         por_req,
    input  logic         bor_req,
    input  logic         boot_done,
    output logic         mem_rd_req,
    output logic [W-1:0] mem_rd_addr,
    input  logic         mem_rd_valid,
    input  logic [W-1:0] mem_rd_data,
    output logic         pc_load,
    output logic [W-1:0] pc_value,
    output logic         sr_clear,
    output logic         wdt_enable,
    output logic         wdt_interval_mode,
    output logic         pin_nmi_sel,
    output logic         cpu_run,
    output logic         lpm4_enter
);
    logic       any_rst;
    logic       blank;
    seq_state_t state;
    sys_cfg_t   cfg;

    reset_gather #(.N_SRC(3)) u_rst (
        .src     ({rst, por_req, bor_req}),
        .any_rst (any_rst)
    );

    assign blank = word_is_blank(mem_rd_data, BLANK_WORD);

    seq_fsm u_fsm (
        .clk       (clk),
        .any_rst   (any_rst),
        .boot_done (boot_done),
        .rd_valid  (mem_rd_valid),
        .blank     (blank),
        .state     (state)
    );

    pc_loader #(.W(W), .BOOT_ADDR(BOOT_ADDR)) u_pc (
        .clk      (clk),
        .any_rst  (any_rst),
        .state    (state),
        .rd_valid (mem_rd_valid),
        .rd_data  (mem_rd_data),
        .blank    (blank),
        .load     (pc_load),
        .value    (pc_value)
    );

    sys_defaults u_cfg (
        .clk     (clk),
        .any_rst (any_rst),
        .cfg     (cfg)
    );

    assign mem_rd_req        = (state == ST_VFETCH);
    assign mem_rd_addr       = VEC_ADDR;
    assign sr_clear          = (state == ST_HOLD);
    assign cpu_run           = (state == ST_RUN);
    assign lpm4_enter        = (state == ST_PARK);
    assign wdt_enable        = cfg.wdt_en;
    assign wdt_interval_mode = cfg.wdt_interval;
    assign pin_nmi_sel       = cfg.nmi_sel;
endmodule

// File: rtl/boot_entry_seq_chk.sv
module boot_entry_seq_chk #(
    parameter int           W          = 16,
    parameter logic [W-1:0] BOOT_ADDR  = 16'hC000,
    parameter logic [W-1:0] VEC_ADDR   = 16'hFFFE,
    parameter logic [W-1:0] BLANK_WORD = 16'hFFFF
) (
    input logic         clk,
    input logic         rst,
    input logic         por_req,
    input logic         bor_req,
    input logic         mem_rd_req,
    input logic [W-1:0] mem_rd_addr,
    input logic         mem_rd_valid,
    input logic [W-1:0] mem_rd_data,
    input logic         pc_load,
    input logic [W-1:0] pc_value,
    input logic         sr_clear,
    input logic         wdt_enable,
    input logic         wdt_interval_mode,
    input logic         pin_nmi_sel,
    input logic         cpu_run,
    input logic         lpm4_enter
);
    a_r1_hold_on_request: assert property (@(posedge clk) disable iff (rst)
        (por_req || bor_req) |=> (sr_clear && !cpu_run && !lpm4_enter && !mem_rd_req && !pc_load));

    a_r3_r4_safe_defaults: assert property (@(posedge clk) disable iff (rst)
        sr_clear |=> (wdt_enable && !wdt_interval_mode && !pin_nmi_sel));

    a_r5_boot_entry_load: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_clear) |-> (pc_load && pc_value == BOOT_ADDR));

    a_r6_vector_address: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_rd_addr == VEC_ADDR));

    a_r7_wait_for_valid: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid && !por_req && !bor_req) |=> mem_rd_req);

    a_r8_jump_to_vector: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && mem_rd_data != BLANK_WORD && !por_req && !bor_req)
        |=> (cpu_run && pc_load && pc_value == $past(mem_rd_data)));

    a_r9_blank_parks: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && mem_rd_data == BLANK_WORD && !por_req && !bor_req)
        |=> (lpm4_enter && !pc_load && !cpu_run));

    a_r5_single_cycle_load: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    a_r11_run_is_sticky: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && !por_req && !bor_req) |=> (cpu_run && !pc_load));

    a_r2_one_state_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sr_clear, cpu_run, lpm4_enter, mem_rd_req}));
endmodule

bind boot_entry_seq boot_entry_seq_chk #(
    .W(W), .BOOT_ADDR(BOOT_ADDR), .VEC_ADDR(VEC_ADDR), .BLANK_WORD(BLANK_WORD)
) u_chk (.*);

// File: tb/boot_entry_seq_bench.sv
module boot_entry_seq_bench;
    localparam logic [15:0] BOOT_A = 16'hC000;

    logic        clk = 1'b0;
    logic        rst, por_req, bor_req, boot_done, mem_rd_valid;
    logic [15:0] mem_rd_data;
    logic        mem_rd_req, pc_load, sr_clear, wdt_enable, wdt_interval_mode;
    logic        pin_nmi_sel, cpu_run, lpm4_enter;
    logic [15:0] mem_rd_addr, pc_value;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    boot_entry_seq u_boot_entry_seq (
        .clk(clk), .rst(rst), .por_req(por_req), .bor_req(bor_req), .boot_done(boot_done),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .pc_load(pc_load), .pc_value(pc_value), .sr_clear(sr_clear),
        .wdt_enable(wdt_enable), .wdt_interval_mode(wdt_interval_mode), .pin_nmi_sel(pin_nmi_sel),
        .cpu_run(cpu_run), .lpm4_enter(lpm4_enter)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: every load strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (!rst && pc_load) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected pc_load", pc_value, 16'h0000);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(pc_value == e, "R5/R8 pc_value", pc_value, e);
            end
        end
    end

    // leave hold, expect the boot entry load
    task automatic release_all();
        rst = 0; por_req = 0; bor_req = 0;
        exp_q.push_back(BOOT_A);
        tick();
        chk(!sr_clear, "R2 sr_clear low in boot", {15'd0, sr_clear}, 16'h0);
    endtask

    task automatic finish_boot();
        boot_done = 1; tick(); boot_done = 0;
        chk(mem_rd_req && mem_rd_addr == 16'hFFFE, "R6 read request", mem_rd_addr, 16'hFFFE);
    endtask

    initial begin
        rst = 1; por_req = 0; bor_req = 0; boot_done = 0; mem_rd_valid = 0; mem_rd_data = 16'h0;
        repeat (3) tick();
        chk(sr_clear && !cpu_run && !pc_load && !mem_rd_req, "R1 hold under rst", {15'd0, sr_clear}, 16'h1);
        chk(wdt_enable && !wdt_interval_mode, "R3 watchdog defaults", {14'd0, wdt_enable, wdt_interval_mode}, 16'h2);
        chk(!pin_nmi_sel, "R4 pin in reset function", {15'd0, pin_nmi_sel}, 16'h0);

        // first boot, normal vector
        release_all();
        repeat (3) tick();
        chk(!mem_rd_req, "R6 no read before boot_done", {15'd0, mem_rd_req}, 16'h0);
        finish_boot();
        mem_rd_data = 16'h1234;
        repeat (3) tick();
        chk(mem_rd_req && !cpu_run && !lpm4_enter, "R7 wait for valid", {15'd0, mem_rd_req}, 16'h1);
        mem_rd_valid = 1; mem_rd_data = 16'h5A3C; exp_q.push_back(16'h5A3C);
        tick(); mem_rd_valid = 0;
        chk(cpu_run && !mem_rd_req, "R8 run after vector", {15'd0, cpu_run}, 16'h1);
        boot_done = 1; tick(); boot_done = 0; tick();
        chk(cpu_run && !mem_rd_req, "R11 boot_done ignored in run", {15'd0, cpu_run}, 16'h1);

        // power-on reset, blank part
        por_req = 1; tick();
        chk(sr_clear && !cpu_run, "R1 hold under por_req", {15'd0, sr_clear}, 16'h1);
        release_all();
        finish_boot();
        mem_rd_valid = 1; mem_rd_data = 16'hFFFF; tick(); mem_rd_valid = 0;
        chk(lpm4_enter && !cpu_run, "R9 blank parks", {15'd0, lpm4_enter}, 16'h1);
        boot_done = 1; mem_rd_valid = 1; mem_rd_data = 16'h2222;
        repeat (3) tick();
        boot_done = 0; mem_rd_valid = 0;
        chk(lpm4_enter && !mem_rd_req, "R9 R11 stays parked", {15'd0, lpm4_enter}, 16'h1);

        // brown-out colliding with read-valid
        bor_req = 1; tick();
        chk(sr_clear && !lpm4_enter, "R1 hold under bor_req", {15'd0, sr_clear}, 16'h1);
        release_all();
        finish_boot();
        mem_rd_valid = 1; mem_rd_data = 16'h7777; bor_req = 1; tick();
        mem_rd_valid = 0; bor_req = 0;
        chk(sr_clear && !cpu_run && !pc_load, "R10 reset beats valid", {15'd0, cpu_run}, 16'h0);
        exp_q.push_back(BOOT_A);
        tick();
        finish_boot();
        mem_rd_valid = 1; mem_rd_data = 16'h8000; exp_q.push_back(16'h8000); tick(); mem_rd_valid = 0;
        chk(cpu_run, "R8 second vector", {15'd0, cpu_run}, 16'h1);

        // power-on colliding with boot_done
        por_req = 1; tick(); por_req = 0;
        exp_q.push_back(BOOT_A); tick();
        boot_done = 1; por_req = 1; tick(); boot_done = 0; por_req = 0;
        chk(sr_clear && !mem_rd_req, "R10 reset beats boot_done", {15'd0, mem_rd_req}, 16'h0);
        exp_q.push_back(BOOT_A); tick();
        tick();
        chk(!mem_rd_req && !sr_clear, "R10 back in boot", {15'd0, mem_rd_req}, 16'h0);
        repeat (2) tick();
        chk(exp_q.size() == 0, "R5 all loads seen", 16'(exp_q.size()), 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule